// File: doc/BRIEF.md
# Multi-cycle processor main controller

This block is the finite-state sequencer of a 32-bit load/store processor that reuses a single memory and a single ALU over several short cycles. It watches the 6-bit opcode held in the instruction register and the ALU zero flag. In every cycle it drives the datapath control lines: the program counter and instruction register write enables, the memory address source, the memory and register-file write enables, the destination-register and write-back selects, the two ALU operand selects, the ALU operation class, and the latch enables for the branch target, the ALU result register and the memory data register.

Every instruction starts with a fetch cycle and then a decode cycle. The decode cycle always forms the branch target (incremented PC plus the word-scaled sign-extended offset) and latches it, whatever the opcode is. This lets a branch finish in its third cycle. Loads and stores share one address-calculation state whose sum is kept in the ALU result register. A load then reads memory into the data register and writes that register back to the register file. A store writes memory and returns to fetch. A register-register instruction executes with the ALU operation given by the function field and then writes rd. A branch-equal subtracts and, when the zero flag is set, loads PC from the latched target. An opcode outside the supported set raises a one-cycle flag in decode and goes straight back to fetch.

Top module: `mcyc_sequencer`

## Requirements
- R1: While `rst_n` is low, every write or latch enable (`pc_wr`, `ir_wr`, `mem_wr`, `rf_wr`, `tgt_wr`, `res_wr`, `dr_wr`) and `illegal` are 0. The first cycle after release is a fetch cycle.
- R2: Fetch cycle: `ir_wr`=1, `pc_wr`=1, `pc_src`=0, `addr_sel`=0, `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_class`=00 (add).
- R3: Decode cycle, for every opcode: `tgt_wr`=1, `alu_a_sel`=0, `alu_b_sel`=11 (sign-extended immediate shifted left by 2), `alu_class`=00. PC, register file and memory are not written.
- R4: For lw (opcode 100011) and sw (opcode 101011), the cycle after decode is the address cycle: `alu_a_sel`=1 (rs), `alu_b_sel`=10 (sign-extended immediate), `alu_class`=00, `res_wr`=1.
- R5: lw memory-read cycle: `addr_sel`=1 (address from the ALU result register), `dr_wr`=1, `mem_wr`=0.
- R6: lw write-back cycle: `rf_wr`=1, `dst_sel`=0 (rt), `wb_sel`=1 (data register).
- R7: sw memory-write cycle: `addr_sel`=1, `mem_wr`=1. The next cycle is a fetch.
- R8: For R-type (opcode 000000), the cycle after decode is execute: `alu_a_sel`=1, `alu_b_sel`=00 (rt), `alu_class`=10 (from the function field), `res_wr`=1.
- R9: R-type write-back cycle: `rf_wr`=1, `dst_sel`=1 (rd), `wb_sel`=0 (ALU result register).
- R10: For beq (opcode 000100), the cycle after decode is the completion cycle: `alu_a_sel`=1, `alu_b_sel`=00, `alu_class`=01 (subtract), `pc_src`=1 (branch target), and `pc_wr` equals `zero`.
- R11: Any other opcode asserts `illegal` for the decode cycle only, and the next cycle is a fetch. No PC, register-file or memory write occurs for that instruction after its fetch.
- R12: Counting from its fetch cycle to the next fetch, lw takes 5 cycles, sw 4, R-type 4 and beq 3 (2 for an illegal opcode).
- R13: Any select or enable not named for a cycle in R2 to R11 is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | Program counter write enable |
| pc_src | output | 1 | PC source: 0 ALU output, 1 latched branch target |
| ir_wr | output | 1 | Instruction register write enable |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result register |
| mem_wr | output | 1 | Memory write enable |
| dr_wr | output | 1 | Memory data register latch enable |
| rf_wr | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination: 0 rt, 1 rd |
| wb_sel | output | 1 | Write-back data: 0 ALU result register, 1 data register |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 rs |
| alu_b_sel | output | 2 | ALU B operand: 00 rt, 01 four, 10 immediate, 11 immediate times 4 |
| alu_class | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| res_wr | output | 1 | ALU result register latch enable |
| tgt_wr | output | 1 | Branch target latch enable |
| illegal | output | 1 | Unsupported opcode seen in decode |

## Verification
The checks take for granted that `opcode` stays stable from the decode cycle until the next fetch, because the instruction register only changes when `ir_wr` is high. They also take for granted that `zero` reflects the ALU output in the same cycle. The bench changes `opcode` and `zero` only at the negative edge that begins a fetch cycle and holds them for the whole instruction. The branch completion is tried with `zero` both high and low, and more than one unsupported opcode is applied, so both outcomes are covered.

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer #(
  parameter logic [5:0] OP_RTYPE = 6'b000000,
  parameter logic [5:0] OP_LOAD  = 6'b100011,
  parameter logic [5:0] OP_STORE = 6'b101011,
  parameter logic [5:0] OP_BREQ  = 6'b000100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic       zero,
  output logic       pc_wr,
  output logic       pc_src,
  output logic       ir_wr,
  output logic       addr_sel,
  output logic       mem_wr,
  output logic       dr_wr,
  output logic       rf_wr,
  output logic       dst_sel,
  output logic       wb_sel,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_class,
  output logic       res_wr,
  output logic       tgt_wr,
  output logic       illegal
);

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_MREAD, ST_LDWB,
    ST_MWRITE, ST_EXEC, ST_RWB, ST_BRANCH
  } st_t;

  st_t st, st_nx;

  wire is_ld  = (opcode == OP_LOAD);
  wire is_st  = (opcode == OP_STORE);
  wire is_rt  = (opcode == OP_RTYPE);
  wire is_beq = (opcode == OP_BREQ);
  wire known  = is_ld | is_st | is_rt | is_beq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_FETCH;
    else        st <= st_nx;

  always_comb begin
    st_nx = ST_FETCH;
    case (st)
      ST_FETCH:  st_nx = ST_DECODE;
      ST_DECODE: begin
        if (is_ld | is_st) st_nx = ST_ADDR;
        else if (is_rt)    st_nx = ST_EXEC;
        else if (is_beq)   st_nx = ST_BRANCH;
        else               st_nx = ST_FETCH;
      end
      ST_ADDR:   st_nx = is_ld ? ST_MREAD : ST_MWRITE;
      ST_MREAD:  st_nx = ST_LDWB;
      ST_EXEC:   st_nx = ST_RWB;
      default:   st_nx = ST_FETCH;
    endcase
  end

  always_comb begin
    pc_wr = 1'b0; pc_src = 1'b0; ir_wr = 1'b0; addr_sel = 1'b0;
    mem_wr = 1'b0; dr_wr = 1'b0; rf_wr = 1'b0; dst_sel = 1'b0;
    wb_sel = 1'b0; alu_a_sel = 1'b0; alu_b_sel = 2'b00;
    alu_class = 2'b00; res_wr = 1'b0; tgt_wr = 1'b0; illegal = 1'b0;
    if (rst_n) begin
      case (st)
        ST_FETCH: begin
          ir_wr = 1'b1; pc_wr = 1'b1; alu_b_sel = 2'b01;
        end
        ST_DECODE: begin
          tgt_wr = 1'b1; alu_b_sel = 2'b11; illegal = !known;
        end
        ST_ADDR: begin
          alu_a_sel = 1'b1; alu_b_sel = 2'b10; res_wr = 1'b1;
        end
        ST_MREAD: begin
          addr_sel = 1'b1; dr_wr = 1'b1;
        end
        ST_LDWB: begin
          rf_wr = 1'b1; wb_sel = 1'b1;
        end
        ST_MWRITE: begin
          addr_sel = 1'b1; mem_wr = 1'b1;
        end
        ST_EXEC: begin
          alu_a_sel = 1'b1; alu_class = 2'b10; res_wr = 1'b1;
        end
        ST_RWB: begin
          rf_wr = 1'b1; dst_sel = 1'b1;
        end
        ST_BRANCH: begin
          alu_a_sel = 1'b1; alu_class = 2'b01; pc_src = 1'b1; pc_wr = zero;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mcyc_sequencer_chk.sv
module mcyc_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] opcode,
  input logic       zero,
  input logic       pc_wr,
  input logic       pc_src,
  input logic       ir_wr,
  input logic       addr_sel,
  input logic       mem_wr,
  input logic       dr_wr,
  input logic       rf_wr,
  input logic       dst_sel,
  input logic       wb_sel,
  input logic       alu_a_sel,
  input logic [1:0] alu_b_sel,
  input logic [1:0] alu_class,
  input logic       res_wr,
  input logic       tgt_wr,
  input logic       illegal
);

  // R1
  always @(posedge clk)
    if (!rst_n)
      reset_quiet_chk: assert (!(pc_wr | ir_wr | mem_wr | rf_wr | tgt_wr | res_wr | dr_wr | illegal));

  // R2
  fetch_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |-> (pc_wr && !pc_src && !addr_sel && alu_b_sel == 2'b01));

  // R3
  decode_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (tgt_wr && !pc_wr && !rf_wr && !mem_wr));

  // R5
  read_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |-> (addr_sel && !mem_wr && $past(res_wr)));

  // R6
  load_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr && wb_sel) |-> ($past(dr_wr) && !dst_sel));

  // R7
  store_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_wr);

  // R9
  rtype_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr && dst_sel) |-> ($past(alu_class) == 2'b10 && !wb_sel));

  // R10
  branch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src) |-> (zero && alu_class == 2'b01));

  // R11
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> (ir_wr && !illegal));

  // R11
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!pc_wr && !rf_wr && !mem_wr));

  // R13
  one_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ir_wr, tgt_wr, res_wr, dr_wr, rf_wr, mem_wr}));

endmodule

bind mcyc_sequencer mcyc_sequencer_chk u_chk (.*);

// File: tb/sim_mcyc_sequencer.sv
module sim_mcyc_sequencer;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'b0;
  logic zero = 1'b0;
  logic pc_wr, pc_src, ir_wr, addr_sel, mem_wr, dr_wr, rf_wr, dst_sel, wb_sel;
  logic alu_a_sel, res_wr, tgt_wr, illegal;
  logic [1:0] alu_b_sel, alu_class;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcyc_sequencer u0 (.*);

  wire [16:0] obs = {pc_wr, ir_wr, addr_sel, mem_wr, rf_wr, dst_sel, wb_sel,
                     alu_a_sel, alu_b_sel, alu_class, tgt_wr, pc_src, dr_wr, res_wr, illegal};

  //                        pc ir ad mw rf ds wb aa  bsel  cls  tg ps dr rs il
  localparam logic [16:0] W_IDLE = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [16:0] W_F    = {1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [16:0] W_D    = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0};
  localparam logic [16:0] W_DX   = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,1'b1,1'b0,1'b0,1'b0,1'b1};
  localparam logic [16:0] W_A    = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0};
  localparam logic [16:0] W_MR   = {1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b1,1'b0,1'b0};
  localparam logic [16:0] W_LW   = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [16:0] W_MW   = {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [16:0] W_EX   = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b10,1'b0,1'b0,1'b0,1'b1,1'b0};
  localparam logic [16:0] W_RW   = {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
  localparam logic [16:0] W_BT   = {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b01,1'b0,1'b1,1'b0,1'b0,1'b0};
  localparam logic [16:0] W_BN   = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b01,1'b0,1'b1,1'b0,1'b0,1'b0};

  task automatic check(input string tag, input logic [16:0] exp);
    n_chk++;
    if (obs !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, obs, exp, $time);
    end
  endtask

  // Entered just after a negedge with the design in fetch; leaves it the same way.
  task automatic run_instr(input string tag, input logic [5:0] op, input logic z,
                           input int n, input logic [16:0] w2, input logic [16:0] w3,
                           input logic [16:0] w4, input logic [16:0] w5);
    opcode = op;
    zero = z;
    #1 check({tag, " fetch R2"}, W_F);
    for (int k = 2; k <= n; k++) begin
      @(negedge clk); #1;
      case (k)
        2: check({tag, " decode R3"}, w2);
        3: check({tag, " step3 R13"}, w3);
        4: check({tag, " step4 R13"}, w4);
        default: check({tag, " step5 R13"}, w5);
      endcase
    end
    @(negedge clk); #1;
    check({tag, " length R12"}, W_F);
  endtask

  task automatic t_reset();
    #2 check("R1 in reset", W_IDLE);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_load();   run_instr("lw R4 R5 R6", 6'b100011, 1'b0, 5, W_D, W_A, W_MR, W_LW); endtask
  task automatic t_store();  run_instr("sw R4 R7", 6'b101011, 1'b1, 4, W_D, W_A, W_MW, W_IDLE); endtask
  task automatic t_rtype();  run_instr("rtype R8 R9", 6'b000000, 1'b1, 4, W_D, W_EX, W_RW, W_IDLE); endtask
  task automatic t_beq_tk(); run_instr("beq taken R10", 6'b000100, 1'b1, 3, W_D, W_BT, W_IDLE, W_IDLE); endtask
  task automatic t_beq_nt(); run_instr("beq not taken R10", 6'b000100, 1'b0, 3, W_D, W_BN, W_IDLE, W_IDLE); endtask
  task automatic t_bad1();   run_instr("illegal 000010 R11", 6'b000010, 1'b1, 2, W_DX, W_IDLE, W_IDLE, W_IDLE); endtask
  task automatic t_bad2();   run_instr("illegal 111111 R11", 6'b111111, 1'b0, 2, W_DX, W_IDLE, W_IDLE, W_IDLE); endtask

  task automatic t_midreset();
    opcode = 6'b100011;
    @(negedge clk); @(negedge clk); #1;
    check("R4 before mid reset", W_A);
    rst_n = 1'b0;
    #1 check("R1 mid reset", W_IDLE);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 fetch after reset", W_F);
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk); #1;
    check("R12 after mid reset", W_F);
  endtask

  initial begin
    t_reset();
    t_load();
    t_store();
    t_rtype();
    t_beq_tk();
    t_beq_nt();
    t_bad1();
    t_load();
    t_bad2();
    t_rtype();
    t_midreset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule